// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash model. Each clock in which `wr_en` is high carries one bus write: a byte address and a data byte. The decoder follows the unlock handshake written by the host. When the final cycle of a recognised command arrives, it issues a one-cycle start pulse for a byte program, a sector erase or a whole-array erase, together with the captured target address and data. It also switches an identification mode on and off. While that mode is on, a read multiplexer returns a manufacturer byte and a device byte in place of array data at the two lowest addresses.

Every command starts with the two unlock writes AAh at 555h and 55h at 2AAh. Only the low 15 address bits are compared. The third write picks the branch:

- A0h arms a byte program. The next write of any kind supplies the target.
- 80h opens the erase branch. It needs a second unlock pair, then 10h at 555h for a full erase or 20h at any address for a sector erase.
- 90h enters identification mode.
- F0h leaves identification mode.

A lone F0h written from the idle state also leaves identification mode. Any write that breaks the expected pattern sends the decoder back to idle. While the external `busy` input is high, every write is ignored and the decoder state does not change.

The states are:

| State | Meaning |
|---|---|
| S_READ | Idle |
| S_UNLK1 | First unlock write seen |
| S_UNLK2 | Both unlock writes seen |
| S_PGM_ARM | Program armed |
| S_ERS1 | Erase branch opened |
| S_ERS2 | Second AAh seen |
| S_ERS3 | Second 55h seen |

The transitions are:

- S_READ to S_UNLK1 on AAh at 555h.
- S_UNLK1 to S_UNLK2 on 55h at 2AAh.
- S_UNLK2 to S_PGM_ARM on A0h, or to S_ERS1 on 80h, both at 555h. S_UNLK2 returns to S_READ on 90h or F0h at 555h, which set or clear identification mode.
- S_PGM_ARM to S_READ on any write, which launches the program.
- S_ERS1 to S_ERS2 on AAh at 555h.
- S_ERS2 to S_ERS3 on 55h at 2AAh.
- S_ERS3 to S_READ on any write, which launches an erase if the write is a valid erase code.
- Any other accepted write from a non-idle state goes to S_READ.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) returns the decoder to S_READ. It clears identification mode and all start pulses, and it discards any partial sequence.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then any write (A, D) raises prog_start for exactly one cycle, starting the cycle after that fourth write is sampled. At the same time op_addr equals A and op_data equals D.
- R3: The write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raises cerase_start for one cycle, starting the cycle after the sixth write.
- R4: The same five writes followed by 20h at any address A raise serase_start for one cycle. op_addr then equals A with bits 6..0 forced to zero, which selects a 128-byte sector.
- R5: Command matching compares only address bits 14..0. Bits 18..15 of a command write do not matter, but a difference in any of bits 14..0 is a mismatch.
- R6: A write whose address or data differs from the expected pair at any step returns the decoder to S_READ. The remaining writes of that sequence then launch nothing.
- R7: While busy is high, every write is ignored. This covers command starts, unlock steps, identification exit and program data. The sequence position held before busy rose is kept.
- R8: The sequence AAh@555h, 55h@2AAh, 90h@555h sets id_mode. While id_mode is set, a read with rd_addr bits 18..1 all zero returns BFh when bit 0 is 0 and DEV_CODE (default 13h) when bit 0 is 1. Every other address returns array_data.
- R9: id_mode is cleared either by a single F0h write at any address from S_READ, or by AAh@555h, 55h@2AAh, F0h@555h.
- R10: While id_mode is clear, rd_data equals array_data for every address.
- R11: At most one start pulse is high in any cycle, and no start pulse lasts two consecutive cycles. op_addr and op_data change only in a cycle in which a start pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | An internal program or erase is running; writes are ignored |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Data read from the storage array |
| rd_data | output | 8 | Read data after the identification multiplexer |
| id_mode | output | 1 | Identification mode is active |
| prog_start | output | 1 | One-cycle byte-program launch |
| serase_start | output | 1 | One-cycle sector-erase launch |
| cerase_start | output | 1 | One-cycle full-erase launch |
| op_addr | output | ADDR_W | Captured target address (sector-aligned for sector erase) |
| op_data | output | 8 | Captured data byte of the launching write |

## Verification
The assertions check the following on every cycle:

- Reset clearing, R1.
- Pulse exclusivity and single-cycle width, R11.
- Stability of the captured address and data between launches, R11.
- Sector alignment of an erase target, R4.
- Silence of all launches and of id_mode on the cycle after busy is high, R7.
- Array passthrough outside identification mode, R10.

Whether a given write history should launch anything can only be shown by the bench's scenarios. These include sweeps of every third-cycle data byte, single-step corruption of each erase step, high-bit-insensitive addresses, busy windows in the middle of a sequence, and identification reads over a sweep of addresses.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_READ    = 3'd0,
        S_UNLK1   = 3'd1,
        S_UNLK2   = 3'd2,
        S_PGM_ARM = 3'd3,
        S_ERS1    = 3'd4,
        S_ERS2    = 3'd5,
        S_ERS3    = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_PROG   = 2'd1,
        K_SERASE = 2'd2,
        K_CERASE = 2'd3
    } launch_t;

    localparam logic [14:0] CMD_ADDR_A = 15'h0555;
    localparam logic [14:0] CMD_ADDR_B = 15'h02AA;

    localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_ID_ENTER = 8'h90;
    localparam logic [7:0] CODE_ID_LEAVE = 8'hF0;
    localparam logic [7:0] CODE_ALL_ERS  = 8'h10;
    localparam logic [7:0] CODE_SECT_ERS = 8'h20;
    localparam logic [7:0] MAKER_CODE    = 8'hBF;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int CMP_W = 15
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [7:0]       cmp_data,
    output logic             at_a,
    output logic             step_first,
    output logic             step_second,
    output logic             is_program,
    output logic             is_erase,
    output logic             is_id_enter,
    output logic             is_id_leave,
    output logic             is_all_ers,
    output logic             is_sect_ers
);

    logic at_b;

    always_comb begin
        at_a        = (cmp_addr == CMD_ADDR_A[CMP_W-1:0]);
        at_b        = (cmp_addr == CMD_ADDR_B[CMP_W-1:0]);
        step_first  = at_a && (cmp_data == CODE_UNLOCK_A);
        step_second = at_b && (cmp_data == CODE_UNLOCK_B);
        is_program  = (cmp_data == CODE_PROGRAM);
        is_erase    = (cmp_data == CODE_ERASE);
        is_id_enter = (cmp_data == CODE_ID_ENTER);
        is_id_leave = (cmp_data == CODE_ID_LEAVE);
        is_all_ers  = (cmp_data == CODE_ALL_ERS);
        is_sect_ers = (cmp_data == CODE_SECT_ERS);
    end

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SECTOR_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              at_a,
    input  logic              step_first,
    input  logic              step_second,
    input  logic              is_program,
    input  logic              is_erase,
    input  logic              is_id_enter,
    input  logic              is_id_leave,
    input  logic              is_all_ers,
    input  logic              is_sect_ers,
    output logic              id_mode,
    output logic              prog_start,
    output logic              serase_start,
    output logic              cerase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    seq_state_t        state_q, state_d;
    launch_t           launch;
    logic              id_set, id_clr;
    logic              accept;
    logic [ADDR_W-1:0] target_addr;

    assign accept = wr_en && !busy;

    // Sector erase target keeps only the sector-select bits.
    generate
        if (SECTOR_BITS > 0) begin : g_sect_align
            always_comb begin
                target_addr = wr_addr;
                if (launch == K_SERASE)
                    target_addr[SECTOR_BITS-1:0] = '0;
            end
        end else begin : g_no_align
            always_comb target_addr = wr_addr;
        end
    endgenerate

    // Next-state and launch decode.
    always_comb begin
        state_d = state_q;
        launch  = K_NONE;
        id_set  = 1'b0;
        id_clr  = 1'b0;
        if (accept) begin
            unique case (state_q)
                S_READ: begin
                    if (step_first)
                        state_d = S_UNLK1;
                    else if (is_id_leave)
                        id_clr = 1'b1;
                end
                S_UNLK1: begin
                    state_d = step_second ? S_UNLK2 : S_READ;
                end
                S_UNLK2: begin
                    state_d = S_READ;
                    if (at_a) begin
                        if (is_program)
                            state_d = S_PGM_ARM;
                        else if (is_erase)
                            state_d = S_ERS1;
                        else if (is_id_enter)
                            id_set = 1'b1;
                        else if (is_id_leave)
                            id_clr = 1'b1;
                    end
                end
                S_PGM_ARM: begin
                    state_d = S_READ;
                    launch  = K_PROG;
                end
                S_ERS1: begin
                    state_d = step_first ? S_ERS2 : S_READ;
                end
                S_ERS2: begin
                    state_d = step_second ? S_ERS3 : S_READ;
                end
                S_ERS3: begin
                    state_d = S_READ;
                    if (is_all_ers && at_a)
                        launch = K_CERASE;
                    else if (is_sect_ers)
                        launch = K_SERASE;
                end
                default: state_d = S_READ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_READ;
        else
            state_q <= state_d;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mode      <= 1'b0;
            prog_start   <= 1'b0;
            serase_start <= 1'b0;
            cerase_start <= 1'b0;
            op_addr      <= '0;
            op_data      <= '0;
        end else begin
            prog_start   <= (launch == K_PROG);
            serase_start <= (launch == K_SERASE);
            cerase_start <= (launch == K_CERASE);
            if (launch != K_NONE) begin
                op_addr <= target_addr;
                op_data <= wr_data;
            end
            if (id_set)
                id_mode <= 1'b1;
            else if (id_clr)
                id_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/id_read_mux.sv
module id_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter logic [7:0]  DEV_CODE = 8'h13
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);

    logic id_window;

    always_comb begin
        id_window = (rd_addr[ADDR_W-1:1] == '0);
        if (id_mode && id_window)
            rd_data = rd_addr[0] ? DEV_CODE : MAKER_CODE;
        else
            rd_data = array_data;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 19,
    parameter int          CMP_W       = 15,
    parameter int          SECTOR_BITS = 7,
    parameter logic [7:0]  DEV_CODE    = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data,
    output logic              id_mode,
    output logic              prog_start,
    output logic              serase_start,
    output logic              cerase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    logic at_a, step_first, step_second;
    logic is_program, is_erase, is_id_enter, is_id_leave;
    logic is_all_ers, is_sect_ers;

    cmd_match #(.CMP_W(CMP_W)) u_match (
        .cmp_addr    (wr_addr[CMP_W-1:0]),
        .cmp_data    (wr_data),
        .at_a        (at_a),
        .step_first  (step_first),
        .step_second (step_second),
        .is_program  (is_program),
        .is_erase    (is_erase),
        .is_id_enter (is_id_enter),
        .is_id_leave (is_id_leave),
        .is_all_ers  (is_all_ers),
        .is_sect_ers (is_sect_ers)
    );

    cmd_fsm #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .busy         (busy),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .at_a         (at_a),
        .step_first   (step_first),
        .step_second  (step_second),
        .is_program   (is_program),
        .is_erase     (is_erase),
        .is_id_enter  (is_id_enter),
        .is_id_leave  (is_id_leave),
        .is_all_ers   (is_all_ers),
        .is_sect_ers  (is_sect_ers),
        .id_mode      (id_mode),
        .prog_start   (prog_start),
        .serase_start (serase_start),
        .cerase_start (cerase_start),
        .op_addr      (op_addr),
        .op_data      (op_data)
    );

    id_read_mux #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_idmux (
        .id_mode    (id_mode),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int ADDR_W      = 19,
    parameter int SECTOR_BITS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [7:0]        array_data,
    input logic [7:0]        rd_data,
    input logic              id_mode,
    input logic              prog_start,
    input logic              serase_start,
    input logic              cerase_start,
    input logic [ADDR_W-1:0] op_addr,
    input logic [7:0]        op_data
);

    logic any_start;
    assign any_start = prog_start || serase_start || cerase_start;

    // R1: reset clears mode and launches
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!id_mode && !any_start));

    // R11: launches are mutually exclusive
    a_r11_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, serase_start, cerase_start}));

    // R11: no launch lasts two cycles
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !any_start);

    // R11: captured target holds between launches
    a_r11_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_start |-> ($stable(op_addr) && $stable(op_data)));

    // R4: sector erase target is sector aligned
    a_r4_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        serase_start |-> (op_addr[SECTOR_BITS-1:0] == '0));

    // R7: a busy cycle launches nothing
    a_r7_busy_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !any_start);

    // R7: a busy cycle leaves identification mode untouched
    a_r7_busy_id_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));

    // R10: array passthrough outside identification mode
    a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (rd_data == array_data));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .array_data   (array_data),
    .rd_data      (rd_data),
    .id_mode      (id_mode),
    .prog_start   (prog_start),
    .serase_start (serase_start),
    .cerase_start (cerase_start),
    .op_addr      (op_addr),
    .op_data      (op_data)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              busy = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        array_data;
    logic [7:0]        rd_data;
    logic              id_mode;
    logic              prog_start, serase_start, cerase_start;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;

    int checks = 0;
    int fails  = 0;
    logic [2:0] obs;
    logic [2:0] acc;

    always #2.5 clk = ~clk;

    assign array_data = rd_addr[7:0] ^ 8'h3C;

    flash_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data), .id_mode(id_mode),
        .prog_start(prog_start), .serase_start(serase_start),
        .cerase_start(cerase_start), .op_addr(op_addr), .op_data(op_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // obs = {prog, serase, cerase} in the cycle after the write is sampled
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        obs = {prog_start, serase_start, cerase_start};
        acc = acc | obs;
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic exp_id;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {id_mode, prog_start, serase_start, cerase_start}, 4'b0);
        rst_n = 1'b1;

        // R2: byte program
        acc = 0;
        unlock(); wr(19'h00555, 8'hA0);
        chk("R2 no early launch", acc, 3'b000);
        wr(19'h4_1234, 8'h5A);
        chk("R2 program pulse", obs, 3'b100);
        chk("R2 op_addr", op_addr, 19'h4_1234);
        chk("R2 op_data", op_data, 8'h5A);
        // R11: pulse is one cycle, target held while busy
        @(negedge clk);
        chk("R11 pulse ends", {prog_start, serase_start, cerase_start}, 3'b000);
        busy = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 target held", {op_addr, op_data}, {19'h4_1234, 8'h5A});
        busy = 1'b0;

        // R3: chip erase
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
        chk("R3 chip erase pulse", obs, 3'b001);

        // R4: sector erase with sector alignment
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h7_1ABC, 8'h20);
        chk("R4 sector erase pulse", obs, 3'b010);
        chk("R4 sector address", op_addr, 19'h7_1A80);

        // R5: upper address bits ignored, low bits compared
        wr(19'h7_8555, 8'hAA); wr(19'h3_82AA, 8'h55); wr(19'h5_0555, 8'hA0);
        wr(19'h0_0042, 8'h99);
        chk("R5 high bits ignored", obs, 3'b100);
        acc = 0;
        wr(19'h0_0D55, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0);
        wr(19'h0_0043, 8'h98);
        chk("R5 low bit mismatch", acc, 3'b000);

        // R6: corrupt each erase step by data or by address
        for (int kind = 0; kind < 2; kind++) begin
            for (int k = 0; k < 6; k++) begin
                logic [ADDR_W-1:0] sa [6];
                logic [7:0]        sd [6];
                sa = '{19'h555, 19'h2AA, 19'h555, 19'h555, 19'h2AA, 19'h555};
                sd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
                if (kind == 0) sd[k] = sd[k] ^ 8'h01;
                else           sa[k] = sa[k] ^ 19'h1;
                acc = 0;
                for (int s = 0; s < 6; s++) wr(sa[s], sd[s]);
                chk($sformatf("R6 corrupt kind%0d step%0d", kind, k), acc, 3'b000);
            end
        end
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
        chk("R6 recovery after abort", obs, 3'b001);

        // R2 R8 R9: sweep every third-cycle byte
        exp_id = 1'b0;
        for (int x = 0; x < 256; x++) begin
            logic [2:0] e;
            unlock(); wr(19'h00555, 8'(x));
            wr(19'h0_0123, 8'h5A);
            e = (x == 8'hA0) ? 3'b100 : 3'b000;
            if (x == 8'h90) exp_id = 1'b1;
            if (x == 8'hF0) exp_id = 1'b0;
            chk($sformatf("R2 R8 R9 sweep byte %0h", x), {obs, id_mode}, {e, exp_id});
        end

        // R8: identification reads
        unlock(); wr(19'h00555, 8'h90);
        chk("R8 id entered", id_mode, 1'b1);
        for (int i = 0; i < ADDR_W + 2; i++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] e;
            a = (i < 2) ? ADDR_W'(i) : (ADDR_W'(1) << (i - 2)) | ADDR_W'(i & 1);
            rd_addr = a;
            #1;
            if (a[ADDR_W-1:1] == 0) e = a[0] ? 8'h13 : 8'hBF;
            else e = a[7:0] ^ 8'h3C;
            chk($sformatf("R8 id read %0h", a), rd_data, e);
        end

        // R7: id exit ignored while busy
        busy = 1'b1;
        wr(19'h0_0777, 8'hF0);
        chk("R7 exit ignored while busy", id_mode, 1'b1);
        busy = 1'b0;
        // R9: single-write exit
        wr(19'h6_0777, 8'hF0);
        chk("R9 single F0 exit", id_mode, 1'b0);
        // R9: three-cycle exit
        unlock(); wr(19'h00555, 8'h90);
        unlock(); wr(19'h00555, 8'hF0);
        chk("R9 three-cycle exit", id_mode, 1'b0);

        // R10: passthrough outside id mode
        rd_addr = 19'h0; #1;
        chk("R10 passthrough addr0", rd_data, 8'h3C);
        rd_addr = 19'h1; #1;
        chk("R10 passthrough addr1", rd_data, 8'h3D);

        // R7: full program sequence while busy launches nothing
        acc = 0;
        busy = 1'b1;
        unlock(); wr(19'h00555, 8'hA0); wr(19'h100, 8'h77);
        busy = 1'b0;
        wr(19'h101, 8'h76);
        chk("R7 busy sequence ignored", acc, 3'b000);
        // R7: busy mid-sequence keeps position
        unlock();
        busy = 1'b1;
        wr(19'h00555, 8'h11);
        busy = 1'b0;
        wr(19'h00555, 8'hA0); wr(19'h2_2222, 8'h33);
        chk("R7 position kept across busy", {obs, op_data}, {3'b100, 8'h33});

        // R1: reset discards a partial sequence
        unlock(); wr(19'h00555, 8'hA0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        acc = 0;
        wr(19'h200, 8'h12);
        chk("R1 partial sequence dropped", acc, 3'b000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule